// File: doc/BRIEF.md
# Operand Shifter with Carry Rotate

This block sits on the second-operand path in front of an ALU. It takes a word, a shift count, a shift kind and the current carry flag. It returns the shifted word and a shifter carry that the flag logic uses. The first operand never passes through it.

Five kinds are supported:

- logical left;
- logical right;
- arithmetic right;
- rotate right;
- a one-step extended rotate through the carry flag, in which the flag acts as an extra bit placed above the sign bit.

The block is purely combinational, so its outputs follow its inputs within the same cycle. Left shifts reuse the right-shifting log stages: the word is bit-reversed before the stages and reversed again after them. The word width must be a power of two.

Top module: `operand_shifter`

## Requirements
- R1: With kind code 0 (logical left) and a count n from 1 to 31, result_o equals opnd_i shifted toward the MSB by n places, and the n low bits are zero.
- R2: With kind code 1 (logical right) and n from 1 to 31, result_o equals opnd_i shifted toward the LSB by n places, and the n high bits are zero.
- R3: With kind code 2 (arithmetic right) and n from 1 to 31, result_o equals opnd_i shifted toward the LSB by n places, and the n high bits are copies of opnd_i bit 31.
- R4: With kind code 3 (rotate right) and n from 1 to 31, each step moves bit 0 into bit 31, so result_o is opnd_i rotated right by n places.
- R5: For codes 0 to 3 with n from 1 to 31, carry_o is the last bit shifted out. For a left shift that is opnd_i bit 32-n. For the three right kinds it is opnd_i bit n-1, which for rotate right equals the new result_o bit 31.
- R6: For codes 0 to 3 with n equal to 0, result_o equals opnd_i and carry_o equals carry_i.
- R7: With kind code 4 (extended rotate), result_o is {carry_i, opnd_i[31:1]} and carry_o is opnd_i bit 0, whatever the value on amount_i.
- R8: Kind codes 5, 6 and 7 pass opnd_i through unchanged, and carry_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Second operand to be shifted |
| amount_i | input | 5 | Shift count n |
| kind_i | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 extended rotate) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry for the flag logic |

## Verification
The hardest cases to reach are those where the carry comes from the far end of the word: a left shift by one must return bit 31, and a right shift by 31 must return bit 30. Random words rarely make those bits differ from their neighbours, so directed vectors place a lone one or zero exactly at the bit that should leave. The extended rotate is driven with non-zero counts and with both carry values, so a design that wrongly reads the count shows up at once. A long run of random vectors over every kind code and count then follows the directed cases.

// File: rtl/shf_pkg.sv
// Package: shared kind codes and fill selection for the operand shifter.
// Assumes: kind codes are fixed by the instruction decoder upstream.
package shf_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_ROT  = 2'd2
    } fill_e;

endpackage

// File: rtl/shf_right_barrel.sv
// Module: log-stage right shifter. Stage k moves the word 2**k places
// toward the LSB when amt_i[k] is set. The vacated high bits take zeros,
// copies of the input sign bit, or the bits that fell off the bottom
// (rotate). Assumes W is a power of two and AW = log2(W).
module shf_right_barrel
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  fill_e         fill_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] stage [0:AW];

    assign stage[0] = data_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [STEP-1:0] top_bits;

        // Choose what enters the vacated high bits for this stage.
        always_comb begin
            case (fill_i)
                FILL_SIGN: top_bits = {STEP{data_i[W-1]}};
                FILL_ROT:  top_bits = stage[k][STEP-1:0];
                default:   top_bits = '0;
            endcase
        end

        assign stage[k+1] = amt_i[k] ? {top_bits, stage[k][W-1:STEP]} : stage[k];
    end

    assign data_o = stage[AW];

    // Check the guarantees of each fill mode on the final word.
    always_comb begin
        if (fill_i == FILL_ROT) begin
            assert_rot_keeps_ones_R4: assert ($countones(data_o) == $countones(data_i))
                else $error("rotate changed the number of set bits");
        end
        if (fill_i == FILL_ZERO && amt_i != '0) begin
            assert_zero_fill_top_R2: assert (data_o[W-1] == 1'b0)
                else $error("zero fill left the top bit set");
        end
        if (fill_i == FILL_SIGN) begin
            assert_sign_fill_top_R3: assert (data_o[W-1] == data_i[W-1])
                else $error("sign fill changed the sign bit");
        end
    end

endmodule

// File: rtl/shf_carry_pick.sv
// Module: picks the shifter carry for counted shifts. The input word is
// given in right-shift orientation (already reversed for left shifts), so
// the last bit to leave is bit amt-1. A zero count passes the flag through.
module shf_carry_pick #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    input  logic [AW-1:0] amt_i,
    input  logic          carry_i,
    output logic          carry_o
);

    logic [AW-1:0] last_idx;

    // Index of the final bit that leaves the word.
    always_comb begin
        last_idx = amt_i - 1'b1;
        carry_o  = (amt_i == '0) ? carry_i : vec_i[last_idx];
    end

endmodule

// File: rtl/shf_rrx.sv
// Module: one-step extended rotate. The carry flag acts as bit W and
// enters bit W-1, while bit 0 leaves into the carry. The count is not used.
module shf_rrx #(
    parameter int W = 32
) (
    input  logic [W-1:0] data_i,
    input  logic         carry_i,
    output logic [W-1:0] data_o,
    output logic         carry_o
);

    // Move the whole word plus carry one place toward the LSB.
    always_comb begin
        data_o  = {carry_i, data_i[W-1:1]};
        carry_o = data_i[0];
    end

endmodule

// File: rtl/operand_shifter.sv
// Module: second-operand shifter, the top of this block. It is purely
// combinational. A left shift is done by reversing the word, shifting it
// right and reversing it back. Kind codes 5 to 7 pass the operand and
// the carry through. Assumes W is a power of two.
module operand_shifter
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [AW-1:0] amount_i,
    input  logic [2:0]    kind_i,
    input  logic          carry_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o
);

    shift_kind_e  kind;
    fill_e        fill_sel;
    logic [W-1:0] opnd_rev;
    logic [W-1:0] oriented;
    logic [W-1:0] shifted;
    logic [W-1:0] shifted_rev;
    logic [W-1:0] aligned;
    logic         count_carry;
    logic [W-1:0] rrx_data;
    logic         rrx_carry;

    assign kind = shift_kind_e'(kind_i);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign opnd_rev[i]    = opnd_i[W-1-i];
        assign shifted_rev[i] = shifted[W-1-i];
    end

    // Orient the operand and choose the fill for the right-shift stages.
    always_comb begin
        oriented = (kind == SK_LSL) ? opnd_rev : opnd_i;
        case (kind)
            SK_ASR:  fill_sel = FILL_SIGN;
            SK_ROR:  fill_sel = FILL_ROT;
            default: fill_sel = FILL_ZERO;
        endcase
    end

    shf_right_barrel #(.W(W), .AW(AW)) u_barrel (
        .data_i (oriented),
        .amt_i  (amount_i),
        .fill_i (fill_sel),
        .data_o (shifted)
    );

    shf_carry_pick #(.W(W), .AW(AW)) u_carry (
        .vec_i   (oriented),
        .amt_i   (amount_i),
        .carry_i (carry_i),
        .carry_o (count_carry)
    );

    shf_rrx #(.W(W)) u_rrx (
        .data_i  (opnd_i),
        .carry_i (carry_i),
        .data_o  (rrx_data),
        .carry_o (rrx_carry)
    );

    assign aligned = (kind == SK_LSL) ? shifted_rev : shifted;

    // Select the final word and carry by kind.
    always_comb begin
        case (kind_i)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                result_o = aligned;
                carry_o  = count_carry;
            end
            3'd4: begin
                result_o = rrx_data;
                carry_o  = rrx_carry;
            end
            default: begin
                result_o = opnd_i;
                carry_o  = carry_i;
            end
        endcase
    end

    // Relate the top-level ports for each kind.
    always_comb begin
        if (kind_i == 3'd0 && amount_i != '0) begin
            assert_lsl_low_zero_R1: assert (result_o[0] == 1'b0)
                else $error("left shift left bit 0 set");
        end
        if (kind_i <= 3'd3 && amount_i == '0) begin
            assert_zero_count_pass_R6: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("zero count altered the operand or the carry");
        end
        if (kind_i == 3'd4) begin
            assert_rrx_body_R7: assert (result_o[W-2:0] == opnd_i[W-1:1])
                else $error("extended rotate body wrong");
        end
        if (kind_i >= 3'd5) begin
            assert_spare_pass_R8: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("spare code changed the outputs");
        end
    end

endmodule

// File: tb/operand_shifter_bench.sv
// Scoreboard bench: the driver applies a vector and queues the expected
// result, and the monitor pops and compares it away from the clock edge.
module operand_shifter_bench;

    typedef struct {
        logic [31:0] res;
        logic        co;
        string       tag;
        string       ctag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [4:0]  amount;
    logic [2:0]  kind;
    logic        carry;
    logic [31:0] result;
    logic        cout;
    exp_t        sb_q [$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    operand_shifter u_operand_shifter (
        .opnd_i   (opnd),
        .amount_i (amount),
        .kind_i   (kind),
        .carry_i  (carry),
        .result_o (result),
        .carry_o  (cout)
    );

    // Reference model: one bit position per step, written from the requirements.
    function automatic void model(input logic [2:0] k, input logic [4:0] n,
                                  input logic [31:0] v, input logic c,
                                  output logic [31:0] r, output logic co);
        r  = v;
        co = c;
        if (k == 3'd4) begin
            r  = {c, v[31:1]};
            co = v[0];
        end else if (k <= 3'd3) begin
            for (int i = 0; i < 32; i++) begin
                if (i < int'(n)) begin
                    case (k)
                        3'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
                        3'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
                        3'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
                        default: begin co = r[0]; r = {r[0], r[31:1]}; end
                    endcase
                end
            end
        end
    endfunction

    // Driver: apply one vector and queue its expectation.
    task automatic apply(input logic [2:0] k, input logic [4:0] n,
                         input logic [31:0] v, input logic c);
        exp_t e;
        @(posedge clk);
        #1;
        kind = k; amount = n; opnd = v; carry = c;
        model(k, n, v, c, e.res, e.co);
        if (k >= 3'd5) begin
            e.tag = "R8"; e.ctag = "R8";
        end else if (k == 3'd4) begin
            e.tag = "R7"; e.ctag = "R7";
        end else if (n == 5'd0) begin
            e.tag = "R6"; e.ctag = "R6";
        end else begin
            e.ctag = "R5";
            case (k)
                3'd0:    e.tag = "R1";
                3'd1:    e.tag = "R2";
                3'd2:    e.tag = "R3";
                default: e.tag = "R4";
            endcase
        end
        sb_q.push_back(e);
    endtask

    // Monitor: compare the queued expectation at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (result !== e.res) begin
                bad++;
                $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.res);
            end
            total++;
            if (cout !== e.co) begin
                bad++;
                $display("FAIL %s carry actual=%b expected=%b", e.ctag, cout, e.co);
            end
        end
    end

    // Stimulus: reset check, directed corners, then random sweep.
    initial begin
        kind = 3'd0; amount = 5'd0; opnd = 32'h0; carry = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (result !== 32'h0 || cout !== 1'b0) begin
            bad++;
            $display("FAIL R6 reset-time outputs actual=%h/%b expected=0/0", result, cout);
        end
        rst_n = 1'b1;
        // R1/R5: left by one, carry from bit 31
        apply(3'd0, 5'd1, 32'h8000_0001, 1'b0);
        apply(3'd0, 5'd31, 32'h0000_0003, 1'b0);
        // R2/R5: right by 31, carry from bit 30
        apply(3'd1, 5'd31, 32'hC000_0000, 1'b0);
        apply(3'd1, 5'd31, 32'h8000_0000, 1'b1);
        // R3: sign fill on both signs, carry from bits 3 and 4
        apply(3'd2, 5'd4, 32'h8000_0010, 1'b1);
        apply(3'd2, 5'd5, 32'h8000_0010, 1'b0);
        apply(3'd2, 5'd7, 32'h7F00_0000, 1'b0);
        // R4: rotate right
        apply(3'd3, 5'd8, 32'h1234_5678, 1'b1);
        apply(3'd3, 5'd1, 32'h0000_0001, 1'b0);
        // R6: zero count for each counted kind
        for (int k = 0; k < 4; k++) apply(3'(k), 5'd0, 32'hA5A5_0F0F, 1'b1);
        // R7: extended rotate ignores a non-zero count
        apply(3'd4, 5'd17, 32'h0000_0003, 1'b1);
        apply(3'd4, 5'd31, 32'hFFFF_FFFE, 1'b0);
        // R8: spare codes pass through
        apply(3'd5, 5'd3, 32'hDEAD_BEEF, 1'b1);
        apply(3'd6, 5'd9, 32'h0123_4567, 1'b0);
        apply(3'd7, 5'd1, 32'hFFFF_0000, 1'b1);
        // Random sweep over all kinds and counts
        for (int i = 0; i < 600; i++) begin
            apply(3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
                  $urandom(), 1'($urandom_range(0, 1)));
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule